// File: doc/BRIEF.md
# DRAM Refresh Overlap Arbiter

This block sits between a refresh timer and the DRAM strobe drivers. When a refresh is requested it looks at the bus cycle in progress and decides whether the refresh may run alongside it. That decision depends on three things: which memory space the cycle targets, whether the cycle is a read or a write, and which kind of refresh is asked for. If overlap is allowed, the RAS and CAS refresh strobes are driven while the bus cycle continues. If it is not allowed, the request is held until the bus goes idle.

Two refresh kinds are handled: CAS-before-RAS and self-refresh. For a CAS-before-RAS refresh, CAS leads RAS by one cycle. For a self-refresh, both strobes rise together. In both cases the strobes then stay asserted together for a parameterised number of cycles. A one-cycle acknowledge marks the cycle in which the strobes are released. Once a refresh has started, it runs to completion whatever the bus does.

Top module: `refresh_overlap_arbiter`

## Requirements
- R1: While and directly after reset, `ras_o`, `cas_o` and `done_o` are low and no request is pending.
- R2: With `bus_busy` low, a request sampled at a clock edge drives its first strobe in the cycle that follows that edge.
- R3: A CAS-before-RAS refresh (`rfsh_kind`=0) asserts `cas_o` alone for exactly one cycle before `ras_o` rises.
- R4: Both strobes stay high together for `HOLD_CYCLES` cycles. A self-refresh (`rfsh_kind`=1) raises both strobes in the same cycle.
- R5: `done_o` pulses high for one cycle, in the cycle right after the strobes drop. Both strobes are low in that cycle.
- R6: A CAS-before-RAS refresh may start during a read (`bus_wr`=0) to external or multiplexed I/O space (`bus_space`=1).
- R7: A CAS-before-RAS refresh requested during a write (`bus_wr`=1) to space 1 does not start until `bus_busy` is low.
- R8: A self-refresh may start during both reads and writes to space 1.
- R9: Neither refresh kind starts while a cycle to DRAM space (`bus_space`=0) is busy, whether it is a read or a write.
- R10: Both kinds may start during cycles to on-chip memory or peripherals (`bus_space`=2). Code 3 is reserved and never allows overlap.
- R11: A request that cannot start at once is held, never dropped. A request that arrives during a refresh is served after it. Requests that arrive while one is already held merge into it, and the first request's kind is kept.
- R12: Once a refresh has started, later changes of `bus_busy`, `bus_space` or `bus_wr` do not alter its strobe sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_req | input | 1 | Refresh request, sampled each edge |
| rfsh_kind | input | 1 | 0 = CAS-before-RAS, 1 = self-refresh |
| bus_busy | input | 1 | A bus cycle is in progress |
| bus_space | input | 2 | Target: 0 DRAM, 1 external/multiplexed I/O, 2 on-chip, 3 reserved |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| ras_o | output | 1 | RAS refresh strobe, active high |
| cas_o | output | 1 | CAS refresh strobe, active high |
| done_o | output | 1 | One-cycle refresh-complete pulse |

## Verification
Directed cases send each refresh kind against each target space with both directions, keeping the bus busy for many cycles. Any strobe seen during that busy window separates an allowed overlap from a forced wait, so each cell of the overlap table is checked on its own. Further directed cases send a request while a refresh is running, and send several requests while one is already held; these show whether requests are latched and merged, and never lost. A long random run then changes bus activity, space and direction freely while requests arrive. A cycle-accurate reference model catches strobe timing errors, lead-cycle errors and hold-length errors that arise only when bus changes line up with refresh starts.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

    typedef enum logic {
        RK_CBR  = 1'b0,
        RK_SELF = 1'b1
    } rfsh_kind_e;

    typedef enum logic [1:0] {
        SP_DRAM   = 2'd0,
        SP_EXT    = 2'd1,
        SP_ONCHIP = 2'd2,
        SP_RSVD   = 2'd3
    } bus_space_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_HOLD = 2'd2,
        SQ_DONE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic       valid;
        rfsh_kind_e kind;
    } pend_t;

    // Overlap table: may a refresh of kind k run beside a cycle to space s?
    function automatic logic overlap_ok(rfsh_kind_e k, bus_space_e s, logic wr);
        logic ok;
        case (s)
            SP_DRAM:   ok = 1'b0;
            SP_EXT:    ok = (k == RK_SELF) ? 1'b1 : !wr;
            SP_ONCHIP: ok = 1'b1;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/rfa_pending.sv
module rfa_pending
    import rfa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  rfsh_kind_e req_kind,
    input  logic       take,
    output logic       have,
    output rfsh_kind_e kind
);
    pend_t pend_q, pend_d;

    assign have = pend_q.valid | req;
    assign kind = pend_q.valid ? pend_q.kind : req_kind;

    always_comb begin
        pend_d = pend_q;
        if (take) begin
            // a fresh request arriving while the held one launches is kept
            pend_d.valid = pend_q.valid & req;
            pend_d.kind  = req_kind;
        end else if (!pend_q.valid && req) begin
            pend_d.valid = 1'b1;
            pend_d.kind  = req_kind;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '{valid: 1'b0, kind: RK_CBR};
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/rfa_contention.sv
module rfa_contention
    import rfa_pkg::*;
(
    input  logic       bus_busy,
    input  bus_space_e bus_space,
    input  logic       bus_wr,
    input  rfsh_kind_e kind,
    output logic       may_go
);
    assign may_go = !bus_busy || overlap_ok(kind, bus_space, bus_wr);
endmodule

// File: rtl/rfa_sequencer.sv
module rfa_sequencer
    import rfa_pkg::*;
#(
    parameter int HOLD_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  rfsh_kind_e kind,
    output logic       idle,
    output logic       ras,
    output logic       cas,
    output logic       done
);
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

    seq_state_e      st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            SQ_IDLE: begin
                if (start) begin
                    if (kind == RK_CBR) begin
                        st_d = SQ_LEAD;
                    end else begin
                        st_d  = SQ_HOLD;
                        cnt_d = HOLD_LAST;
                    end
                end
            end
            SQ_LEAD: begin
                st_d  = SQ_HOLD;
                cnt_d = HOLD_LAST;
            end
            SQ_HOLD: begin
                if (cnt_q == '0) begin
                    st_d = SQ_DONE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign idle = (st_q == SQ_IDLE);
    assign cas  = (st_q == SQ_LEAD) || (st_q == SQ_HOLD);
    assign ras  = (st_q == SQ_HOLD);
    assign done = (st_q == SQ_DONE);

endmodule

// File: rtl/refresh_overlap_arbiter.sv
module refresh_overlap_arbiter
    import rfa_pkg::*;
#(
    parameter int HOLD_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rfsh_req,
    input  logic       rfsh_kind,
    input  logic       bus_busy,
    input  logic [1:0] bus_space,
    input  logic       bus_wr,
    output logic       ras_o,
    output logic       cas_o,
    output logic       done_o
);
    logic       have;
    rfsh_kind_e pend_kind;
    logic       may_go;
    logic       seq_idle;
    logic       launch;

    rfa_pending u_pending (
        .clk      (clk),
        .rst      (rst),
        .req      (rfsh_req),
        .req_kind (rfsh_kind_e'(rfsh_kind)),
        .take     (launch),
        .have     (have),
        .kind     (pend_kind)
    );

    rfa_contention u_contention (
        .bus_busy  (bus_busy),
        .bus_space (bus_space_e'(bus_space)),
        .bus_wr    (bus_wr),
        .kind      (pend_kind),
        .may_go    (may_go)
    );

    assign launch = seq_idle && have && may_go;

    rfa_sequencer #(.HOLD_CYCLES(HOLD_CYCLES)) u_sequencer (
        .clk   (clk),
        .rst   (rst),
        .start (launch),
        .kind  (pend_kind),
        .idle  (seq_idle),
        .ras   (ras_o),
        .cas   (cas_o),
        .done  (done_o)
    );

endmodule

// File: rtl/rfa_checker.sv
module rfa_checker #(
    parameter int HOLD_CYCLES = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_busy,
    input logic [1:0] bus_space,
    input logic       ras_o,
    input logic       cas_o,
    input logic       done_o
);
    logic [15:0] ras_run;

    always_ff @(posedge clk) begin
        if (rst)        ras_run <= '0;
        else if (ras_o) ras_run <= ras_run + 1'b1;
        else            ras_run <= '0;
    end

    // R3
    ras_needs_cas_chk: assert property (@(posedge clk) disable iff (rst)
        ras_o |-> cas_o);

    // R4
    hold_length_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_o && ras_run != 16'd0) |-> (ras_run == 16'(HOLD_CYCLES)));

    // R5
    done_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!ras_o && !cas_o && $past(ras_o)));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    no_dram_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_o) |-> !($past(bus_busy) && $past(bus_space) == 2'd0));

endmodule

bind refresh_overlap_arbiter rfa_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_rfa_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_busy  (bus_busy),
    .bus_space (bus_space),
    .ras_o     (ras_o),
    .cas_o     (cas_o),
    .done_o    (done_o)
);

// File: tb/test_refresh_overlap_arbiter.sv
module test_refresh_overlap_arbiter;
    localparam int HOLD = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rfsh_req = 1'b0;
    logic       rfsh_kind = 1'b0;
    logic       bus_busy = 1'b0;
    logic [1:0] bus_space = 2'd0;
    logic       bus_wr = 1'b0;
    logic       ras_o, cas_o, done_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string cur_tag = "R1";

    // reference model state
    int  m_st = 0;
    int  m_cnt = 0;
    bit  m_pv = 0;
    bit  m_pk = 0;

    refresh_overlap_arbiter #(.HOLD_CYCLES(HOLD)) i_refresh_overlap_arbiter (
        .clk(clk), .rst(rst), .rfsh_req(rfsh_req), .rfsh_kind(rfsh_kind),
        .bus_busy(bus_busy), .bus_space(bus_space), .bus_wr(bus_wr),
        .ras_o(ras_o), .cas_o(cas_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    function automatic bit ref_ok(bit k, logic [1:0] sp, bit wr);
        case (sp)
            2'd0:    return 1'b0;      // R9
            2'd1:    return k ? 1'b1 : !wr; // R6 R7 R8
            2'd2:    return 1'b1;      // R10
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d {ras,cas,done} actual=%b expected=%b",
                     tag, cycles, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit have, k, launch;
        #2;
        cycles++;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_pv = 0; m_pk = 0;
            check("R1", {ras_o, cas_o, done_o}, 3'b000);
        end else begin
            have   = m_pv | rfsh_req;
            k      = m_pv ? m_pk : rfsh_kind;
            launch = (m_st == 0) && have && (!bus_busy || ref_ok(k, bus_space, bus_wr));
            if (launch) begin
                m_pv = m_pv & rfsh_req;
                m_pk = rfsh_kind;
            end else if (!m_pv && rfsh_req) begin
                m_pv = 1'b1;
                m_pk = rfsh_kind;
            end
            case (m_st)
                0: if (launch) begin
                       if (!k) m_st = 1;
                       else begin m_st = 2; m_cnt = HOLD - 1; end
                   end
                1: begin m_st = 2; m_cnt = HOLD - 1; end
                2: if (m_cnt == 0) m_st = 3; else m_cnt--;
                default: m_st = 0;
            endcase
            check(cur_tag, {ras_o, cas_o, done_o},
                  {m_st == 2, (m_st == 1) || (m_st == 2), m_st == 3});
        end
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run_case(string tag, bit k, bit busy, logic [1:0] sp, bit wr, int busy_len);
        cur_tag = tag;
        @(negedge clk);
        rfsh_req = 1'b1; rfsh_kind = k;
        bus_busy = busy; bus_space = sp; bus_wr = wr;
        @(negedge clk);
        rfsh_req = 1'b0;
        repeat (busy_len) @(negedge clk);
        bus_busy = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 R3 R4 R5: idle bus, both kinds
        run_case("R2", 1'b0, 1'b0, 2'd0, 1'b0, 0);
        run_case("R3", 1'b0, 1'b0, 2'd1, 1'b0, 0);
        run_case("R4", 1'b1, 1'b0, 2'd0, 1'b0, 0);
        run_case("R5", 1'b1, 1'b0, 2'd2, 1'b1, 0);
        // overlap table cells with a long busy window
        run_case("R6", 1'b0, 1'b1, 2'd1, 1'b0, 12);
        run_case("R7", 1'b0, 1'b1, 2'd1, 1'b1, 12);
        run_case("R8", 1'b1, 1'b1, 2'd1, 1'b0, 12);
        run_case("R8", 1'b1, 1'b1, 2'd1, 1'b1, 12);
        run_case("R9", 1'b0, 1'b1, 2'd0, 1'b0, 12);
        run_case("R9", 1'b0, 1'b1, 2'd0, 1'b1, 12);
        run_case("R9", 1'b1, 1'b1, 2'd0, 1'b0, 12);
        run_case("R9", 1'b1, 1'b1, 2'd0, 1'b1, 12);
        run_case("R10", 1'b0, 1'b1, 2'd2, 1'b1, 12);
        run_case("R10", 1'b1, 1'b1, 2'd2, 1'b0, 12);
        run_case("R10", 1'b1, 1'b1, 2'd3, 1'b0, 12);
        // R11: request during a running refresh, then merged requests
        cur_tag = "R11";
        @(negedge clk); rfsh_req = 1'b1; rfsh_kind = 1'b0;
        @(negedge clk); rfsh_req = 1'b0;
        @(negedge clk); rfsh_req = 1'b1; rfsh_kind = 1'b1;
        @(negedge clk); rfsh_req = 1'b1; rfsh_kind = 1'b0;
        @(negedge clk); rfsh_req = 1'b0;
        repeat (20) @(negedge clk);
        bus_busy = 1'b1; bus_space = 2'd0;
        rfsh_req = 1'b1; rfsh_kind = 1'b0;
        @(negedge clk); rfsh_req = 1'b1; rfsh_kind = 1'b1;
        @(negedge clk); rfsh_req = 1'b0;
        repeat (8) @(negedge clk);
        bus_busy = 1'b0;
        repeat (20) @(negedge clk);
        // R12 and mixed: random traffic
        cur_tag = "R12";
        begin
            int seed_val = $urandom(32'h5eed_1234);
            seed_val = seed_val + 0;
        end
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            rfsh_req = ($urandom_range(0, 7) == 0);
            rfsh_kind = $urandom_range(0, 1);
            if ($urandom_range(0, 5) == 0) begin
                bus_busy  = $urandom_range(0, 2) != 0;
                bus_space = 2'($urandom_range(0, 3));
                bus_wr    = $urandom_range(0, 1);
            end
        end
        rfsh_req = 1'b0; bus_busy = 1'b0;
        repeat (20) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule